// File: doc/BRIEF.md
# Self-Flipping Control Point Array

This block holds K independent control points, each placed on one internal signal line of a logic-BIST target. During a multi-cycle capture window, each point compares the value arriving on its line with the value it drove at the previous capture. If the two match, the line has made no transition, and the point drives the inverted value. If they differ, the value passes through. Lines that the capture sequence would otherwise freeze at 0 or 1 therefore keep toggling from one capture to the next. No control vector has to be supplied per cycle.

A single enable, driven by the BIST controller, arms the flipping. The controller holds it low during shift and during normal operation, so the array is then a plain wire. A capture strobe marks each capture clock. The stored value of each point changes only on that strobe. The stored value is cleared while the enable is low. The first capture after the enable rises loads the line value unchanged, so every new pattern starts with a pass-through capture.

Top module: `sfcp_array`

## Requirements
- R1: After reset, every stored value is 0 and the output of each point equals its input.
- R2: While `cap_en_i` is 0, `line_o` equals `line_i` on every bit, whatever the strobe does.
- R3: The first capture strobe after `cap_en_i` rises passes `line_i` to `line_o` unchanged and loads that value as the stored value.
- R4: With the array enabled and armed, a bit whose input equals its stored value is driven inverted on `line_o`.
- R5: With the array enabled and armed, a bit whose input differs from its stored value passes through unchanged.
- R6: With the array enabled and armed, the output at each capture strobe is the bitwise complement of the output at the previous capture strobe.
- R7: The stored values change only on a cycle with both `cap_en_i` and `cap_strobe_i` at 1. Input changes between strobes do not alter them.
- R8: Taking `cap_en_i` low clears every stored value and disarms the array. The next enabled window begins again with a pass-through capture.
- R9: Each bit of the array behaves according to its own input and stored value only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_en_i | input | 1 | Flip enable from the BIST controller, high during capture |
| cap_strobe_i | input | 1 | Marks a capture clock edge |
| line_i | input | K | Values arriving on the controlled lines |
| line_o | output | K | Values driven onward on the controlled lines |

## Verification
The bench targets the first capture after each enable. A design that flips on that capture would invert lines that hold 0 out of reset, which breaks R3 and R8. It drives all-constant inputs to check that the output alternates. A design that compares against its input rather than its own last output would stop toggling there. It changes inputs between strobes to catch a stored value that updates on every clock, and it strobes while disabled to catch a design that is not transparent. Mixed vectors, with some bits constant and others moving, expose any coupling between points.

// File: rtl/sfcp_pkg.sv
package sfcp_pkg;

  // a point flips when armed and the line shows no transition since last capture
  function automatic logic cp_drive(input logic armed, input logic in_v, input logic prev_v);
    return (armed && (in_v == prev_v)) ? ~in_v : in_v;
  endfunction

endpackage

// File: rtl/sfcp_arm.sv
module sfcp_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic cap_strobe_i,
  output logic armed_o,
  output logic fire_o
);

  logic armed_q;

  assign fire_o  = cap_en_i & cap_strobe_i;
  assign armed_o = cap_en_i & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (!cap_en_i) armed_q <= 1'b0;
    else if (fire_o)    armed_q <= 1'b1;
  end

endmodule

// File: rtl/sfcp_cell.sv
module sfcp_cell
  import sfcp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic armed_i,
  input  logic fire_i,
  input  logic line_i,
  output logic line_o,
  output logic prev_o
);

  logic prev_q;

  assign line_o = cp_drive(armed_i, line_i, prev_q);
  assign prev_o = prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        prev_q <= 1'b0;
    else if (!cap_en_i) prev_q <= 1'b0;
    else if (fire_i)    prev_q <= line_o;
  end

endmodule

// File: rtl/sfcp_array.sv
module sfcp_array #(
  parameter int unsigned K = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_en_i,
  input  logic         cap_strobe_i,
  input  logic [K-1:0] line_i,
  output logic [K-1:0] line_o
);

  logic         armed;
  logic         fire;
  logic [K-1:0] prev_q;

  sfcp_arm u_arm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_en_i     (cap_en_i),
    .cap_strobe_i (cap_strobe_i),
    .armed_o      (armed),
    .fire_o       (fire)
  );

  for (genvar g = 0; g < K; g++) begin : g_cp
    sfcp_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cap_en_i (cap_en_i),
      .armed_i  (armed),
      .fire_i   (fire),
      .line_i   (line_i[g]),
      .line_o   (line_o[g]),
      .prev_o   (prev_q[g])
    );
  end

endmodule

// File: rtl/sfcp_array_chk.sv
module sfcp_array_chk #(
  parameter int unsigned K = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cap_en_i,
  input logic         cap_strobe_i,
  input logic [K-1:0] line_i,
  input logic [K-1:0] line_o,
  input logic [K-1:0] prev_i
);

  logic         seen_q;
  logic [K-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (!cap_en_i) begin
      seen_q <= 1'b0;
    end else if (cap_strobe_i) begin
      seen_q <= 1'b1;
      last_q <= line_o;
    end
  end

  p_transparent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |-> line_o == line_i);

  p_first_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && cap_strobe_i && !seen_q) |-> line_o == line_i);

  p_alternate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && cap_strobe_i && seen_q) |-> line_o == ~last_q);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && !cap_strobe_i) |=> $stable(prev_i));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && cap_strobe_i) |=> prev_i == $past(line_o));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> prev_i == '0);

endmodule

bind sfcp_array sfcp_array_chk #(.K(K)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cap_en_i     (cap_en_i),
  .cap_strobe_i (cap_strobe_i),
  .line_i       (line_i),
  .line_o       (line_o),
  .prev_i       (prev_q)
);

// File: tb/tb_sfcp_array.sv
module tb_sfcp_array;

  localparam int unsigned K = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cap_en_i = 1'b0;
  logic         cap_strobe_i = 1'b0;
  logic [K-1:0] line_i = '0;
  logic [K-1:0] line_o;

  int checks = 0;
  int failures = 0;

  logic [K-1:0] m_prev = '0;
  logic [K-1:0] m_last = '0;
  bit           m_armed = 1'b0;

  sfcp_array #(.K(K)) dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_en_i     (cap_en_i),
    .cap_strobe_i (cap_strobe_i),
    .line_i       (line_i),
    .line_o       (line_o)
  );

  always #5ns clk_i = ~clk_i;

  task automatic chk(input string req, input logic [K-1:0] act, input logic [K-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // expected output from stored value: bits equal to stored value are inverted
  function automatic logic [K-1:0] expect_out(input logic [K-1:0] v);
    return m_armed ? (v ^ ~(v ^ m_prev)) : v;
  endfunction

  task automatic capture(input logic [K-1:0] v, input string tag);
    logic [K-1:0] e;
    @(negedge clk_i);
    line_i = v;
    cap_strobe_i = 1'b1;
    #1;
    e = expect_out(v);
    if (!m_armed) chk({tag, " R3 first capture pass"}, line_o, v);
    else begin
      chk({tag, " R4/R5 flip rule"}, line_o, e);
      chk({tag, " R6 alternation"}, line_o, ~m_last);
    end
    @(posedge clk_i);
    m_prev = e;
    m_last = e;
    m_armed = 1'b1;
    #1 cap_strobe_i = 1'b0;
  endtask

  task automatic idle(input logic [K-1:0] v);
    @(negedge clk_i);
    line_i = v;
    cap_strobe_i = 1'b0;
    #1 chk("R7 no strobe, stored value held", line_o, expect_out(v));
  endtask

  task automatic set_en(input bit b);
    @(negedge clk_i);
    cap_en_i = b;
    if (!b) begin
      m_armed = 1'b0;
      m_prev = '0;
      #1 chk("R2 disabled transparent", line_o, line_i);
    end
  endtask

  initial begin
    #2ms;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    line_i = 4'b1010;
    #12ns;
    chk("R1 reset output equals input", line_o, 4'b1010);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: disabled sweep with strobes toggling
    for (int v = 0; v < 16; v++) begin
      @(negedge clk_i);
      line_i = v[K-1:0];
      cap_strobe_i = v[0];
      #1 chk("R2 transparent when disabled", line_o, v[K-1:0]);
    end
    @(negedge clk_i);
    cap_strobe_i = 1'b0;

    // constant inputs: output must alternate
    for (int c = 0; c < 16; c++) begin
      set_en(1'b1);
      for (int n = 0; n < 5; n++) capture(c[K-1:0], "const");
      set_en(1'b0);
    end

    // moving patterns with idle gaps; re-enable each pattern (R8)
    for (int p = 0; p < 8; p++) begin
      set_en(1'b1);
      for (int n = 0; n < 16; n++) begin
        capture(K'((p * 5 + n * 3) % 16), n == 0 ? "R8 restart" : "walk");
        idle(K'((p + n * 7) % 16));
        idle(K'((n * 11) % 16));
      end
      set_en(1'b0);
    end

    // R9: bit0 held at 1, other bits count
    set_en(1'b1);
    for (int n = 0; n < 16; n++) capture(K'((n << 1) | 1), "R9 independent bits");
    set_en(1'b0);

    // R2 again after a window, with strobe high while disabled
    @(negedge clk_i);
    line_i = 4'b0110;
    cap_strobe_i = 1'b1;
    #1 chk("R2 strobe ignored while disabled", line_o, 4'b0110);
    @(negedge clk_i);
    cap_strobe_i = 1'b0;
    set_en(1'b1);
    capture(4'b0110, "R8 cleared store");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule